// File: doc/BRIEF.md
# Polled Console Port

This block is a small peripheral on a processor's single-cycle load/store bus. It gives software a byte-wide input channel, which behaves like a keyboard, and a byte-wide output channel, which behaves like a display. Both channels live in a reserved address window at the very top of the address space. The window holds no memory, so a request that falls inside it is answered here and is never passed on to the memory port. Any request outside the window goes out on `mem_req`.

Each channel has a control word and a data word. Bit 0 of the control word is a ready flag, seen from the processor's side:
- For input, ready means a byte is waiting.
- For output, ready means the channel can take a byte.

Software polls the flag by masking with 0x1, then moves the byte. The data access itself clears the flag again.

There are two state machines:
- The receiver machine has states `RX_EMPTY` and `RX_FULL`. Transition *arrive* goes from empty to full when a byte comes in on the input stream. Transition *consume* goes from full to empty when the data word is read and no new byte comes in on that cycle.
- The transmitter machine has states `TX_READY` and `TX_BUSY`. Transition *launch* goes from ready to busy on a data-word write. Transition *release* goes from busy to ready when the output side acknowledges.

Top module: `mmio_console`

## Requirements
- R1: A request whose address has upper half 0xFFFF is acknowledged on `bus_ack` in the same cycle and never raises `mem_req`. Any other request raises `mem_req` and not `bus_ack`.
- R2: After reset, the receiver control word (offset 0x0) reads 0, the transmitter control word (offset 0x8) reads 1, and `tx_valid` is 0.
- R3: A byte strobed on `rx_valid`/`rx_byte` sets bit 0 of the receiver control word from the next cycle. A read of the receiver data word (offset 0x4) returns that byte zero-extended to 32 bits.
- R4: Reading the receiver data word clears receiver ready at the clock edge that completes the read.
- R5: A byte that arrives while receiver ready is 1 replaces the stored byte and sets the sticky overrun flag, bit 1 of the receiver control word. Reading the receiver control word clears the flag.
- R6: A write to the transmitter data word (offset 0xC) while transmitter ready is 1 does three things from the next cycle: it presents `wdata[7:0]` on `tx_byte`, it raises `tx_valid`, and it clears ready. Ready returns to 1, and `tx_valid` drops, one cycle after `tx_ack`.
- R7: A write to the transmitter data word while transmitter ready is 0 has no effect: `tx_byte` is unchanged.
- R8: Writes to either control word and to unused offsets in the window change nothing. Reads of unused offsets return 0 and are still acknowledged.
- R9: If a byte arrives in the same cycle as a receiver data read, the read returns the old byte, the new byte is kept, ready stays 1 and overrun is not set.
- R10: If a byte arrives while ready is 1 in the same cycle as a receiver control read, overrun is left set. The read itself returns the flags as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request, one cycle per access |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid in the request cycle |
| bus_ack | output | 1 | Request answered by this block |
| mem_req | output | 1 | Request forwarded to ordinary memory |
| rx_valid | input | 1 | Input byte strobe |
| rx_byte | input | 8 | Input byte |
| tx_valid | output | 1 | Output byte pending |
| tx_byte | output | 8 | Output byte |
| tx_ack | input | 1 | Output side has taken the byte |

## Verification
Two pairs of events can fall on the same cycle. The first pair is a byte arriving while software reads the receiver data word. The second pair is a byte arriving while software reads the receiver control word with overrun already set. The bench provokes each pair by raising `rx_valid` in the same cycle as the bus read. It then checks three things: the value returned by that read, the control word that follows, and the byte left in the data word. A correct design keeps the new byte without flagging overrun in the first pair, and keeps overrun set in the second.

// File: rtl/console_pkg.sv
package console_pkg;
    localparam int unsigned OFF_W = 16;
    localparam logic [OFF_W-1:0] OFF_RX_CTRL = 16'h0000;
    localparam logic [OFF_W-1:0] OFF_RX_DATA = 16'h0004;
    localparam logic [OFF_W-1:0] OFF_TX_CTRL = 16'h0008;
    localparam logic [OFF_W-1:0] OFF_TX_DATA = 16'h000C;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_RX_CTRL, SEL_RX_DATA, SEL_TX_CTRL, SEL_TX_DATA, SEL_UNUSED
    } sel_e;

    typedef enum logic {RX_EMPTY, RX_FULL} rx_state_e;
    typedef enum logic {TX_READY, TX_BUSY} tx_state_e;
endpackage

// File: rtl/console_decode.sv
module console_decode
    import console_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-OFF_W-1:0] WIN_TAG = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output sel_e              sel
);
    localparam int unsigned TAG_W = ADDR_W - OFF_W;

    logic [TAG_W-1:0] tag;
    logic [OFF_W-1:0] off;

    assign tag = addr[ADDR_W-1:OFF_W];
    assign off = addr[OFF_W-1:0];
    assign hit = (tag == WIN_TAG);

    always_comb begin
        if (!hit) begin
            sel = SEL_NONE;
        end else begin
            unique case (off)
                OFF_RX_CTRL: sel = SEL_RX_CTRL;
                OFF_RX_DATA: sel = SEL_RX_DATA;
                OFF_TX_CTRL: sel = SEL_TX_CTRL;
                OFF_TX_DATA: sel = SEL_TX_DATA;
                default:     sel = SEL_UNUSED;
            endcase
        end
    end
endmodule

// File: rtl/console_rx.sv
module console_rx
    import console_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              data_rd,
    input  logic              ctrl_rd,
    output logic              ready,
    output logic              overrun,
    output logic [BYTE_W-1:0] data_q
);
    rx_state_e state_q, state_d;
    logic      ovr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: arrive (EMPTY->FULL), consume (FULL->EMPTY)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (in_vld) state_d = RX_FULL;
            RX_FULL:  if (data_rd && !in_vld) state_d = RX_EMPTY;
            default:  state_d = RX_EMPTY;
        endcase
    end

    // data and sticky overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (in_vld) data_q <= in_byte;
            if (in_vld && (state_q == RX_FULL) && !data_rd) ovr_q <= 1'b1;
            else if (ctrl_rd)                               ovr_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        ready   = (state_q == RX_FULL);
        overrun = ovr_q;
    end
endmodule

// File: rtl/console_tx.sv
module console_tx
    import console_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              out_ack,
    output logic              ready,
    output logic              out_vld,
    output logic [BYTE_W-1:0] out_byte
);
    tx_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_READY;
        else        state_q <= state_d;
    end

    // transitions: launch (READY->BUSY), release (BUSY->READY)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_READY: if (data_wr) state_d = TX_BUSY;
            TX_BUSY:  if (out_ack) state_d = TX_READY;
            default:  state_d = TX_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                            out_byte <= '0;
        else if (data_wr && state_q == TX_READY) out_byte <= wbyte;
    end

    // outputs
    always_comb begin
        ready   = (state_q == TX_READY);
        out_vld = (state_q == TX_BUSY);
    end
endmodule

// File: rtl/mmio_console.sv
module mmio_console
    import console_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic              mem_req,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_ack
);
    localparam int unsigned PAD_W = DATA_W - BYTE_W;

    logic              hit;
    sel_e              sel;
    logic              rx_rdy, rx_ovr, tx_rdy;
    logic [BYTE_W-1:0] rx_data;
    logic              rd_cyc, wr_cyc;

    console_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .hit(hit), .sel(sel)
    );

    assign bus_ack = bus_req & hit;
    assign mem_req = bus_req & ~hit;
    assign rd_cyc  = bus_ack & ~bus_we;
    assign wr_cyc  = bus_ack &  bus_we;

    console_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .in_vld(rx_valid), .in_byte(rx_byte),
        .data_rd(rd_cyc && sel == SEL_RX_DATA),
        .ctrl_rd(rd_cyc && sel == SEL_RX_CTRL),
        .ready(rx_rdy), .overrun(rx_ovr), .data_q(rx_data)
    );

    console_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .data_wr(wr_cyc && sel == SEL_TX_DATA),
        .wbyte(bus_wdata[BYTE_W-1:0]),
        .out_ack(tx_ack),
        .ready(tx_rdy), .out_vld(tx_valid), .out_byte(tx_byte)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_cyc) begin
            unique case (sel)
                SEL_RX_CTRL: bus_rdata = {{(DATA_W-2){1'b0}}, rx_ovr, rx_rdy};
                SEL_RX_DATA: bus_rdata = {{PAD_W{1'b0}}, rx_data};
                SEL_TX_CTRL: bus_rdata = {{(DATA_W-1){1'b0}}, tx_rdy};
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/console_sva.sv
module console_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic        bus_ack,
    input logic        mem_req,
    input logic        rx_valid,
    input logic        tx_valid,
    input logic [7:0]  tx_byte,
    input logic        tx_ack,
    input logic        rx_rdy,
    input logic        rx_ovr
);
    p_ack_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && mem_req));

    p_rx_arrive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_rdy);

    p_rx_consume_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == 32'hFFFF_0004 && !rx_valid) |=> !rx_rdy);

    p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_rdy && !(bus_req && !bus_we && bus_addr == 32'hFFFF_0004)) |=> rx_ovr);

    p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ack) |=> (tx_valid && $stable(tx_byte)));

    p_tx_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && bus_req && bus_we) |=> $stable(tx_byte));
endmodule

bind mmio_console console_sva u_sva (.*);

// File: tb/mmio_console_tb.sv
module mmio_console_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack, mem_req;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_ack = 1'b0;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic ack_s, mem_s;

    localparam logic [31:0] A_RXC = 32'hFFFF_0000, A_RXD = 32'hFFFF_0004,
                            A_TXC = 32'hFFFF_0008, A_TXD = 32'hFFFF_000C;

    always #10 clk = ~clk;

    mmio_console dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d, input bit push = 0,
                      input logic [7:0] b = 8'h0);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        if (push) begin rx_valid = 1; rx_byte = b; end
        #2; d = bus_rdata; ack_s = bus_ack; mem_s = mem_req;
        @(negedge clk);
        bus_req = 0; rx_valid = 0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); rx_valid = 1; rx_byte = b;
        @(negedge clk); rx_valid = 0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R2 tx_valid", {31'b0, tx_valid}, 0);
        rd(A_RXC, d); chk("R2 rx ctrl", d, 0);
        rd(A_TXC, d); chk("R2 tx ctrl", d, 1);
    endtask

    task automatic t_window;
        logic [31:0] d;
        rd(32'h0000_1000, d);
        chk("R1 outside ack", {31'b0, ack_s}, 0);
        chk("R1 outside mem_req", {31'b0, mem_s}, 1);
        rd(A_TXC, d);
        chk("R1 inside ack", {31'b0, ack_s}, 1);
        chk("R1 inside mem_req", {31'b0, mem_s}, 0);
    endtask

    task automatic t_rx_basic;
        logic [31:0] d;
        push(8'hA5);
        rd(A_RXC, d); chk("R3 ready set", d, 1);
        rd(A_RXD, d); chk("R3 data zero-extended", d, 32'h0000_00A5);
        rd(A_RXC, d); chk("R4 ready cleared", d, 0);
    endtask

    task automatic t_overrun;
        logic [31:0] d;
        push(8'h11); push(8'h22);
        rd(A_RXC, d); chk("R5 overrun set", d, 3);
        rd(A_RXC, d); chk("R5 overrun cleared by ctrl read", d, 1);
        rd(A_RXD, d); chk("R5 newest byte kept", d, 32'h22);
    endtask

    task automatic t_tx;
        logic [31:0] d;
        wr(A_TXD, 32'h1234_5642);
        chk("R6 tx_valid up", {31'b0, tx_valid}, 1);
        chk("R6 tx_byte", {24'b0, tx_byte}, 32'h42);
        rd(A_TXC, d); chk("R6 ready cleared", d, 0);
        wr(A_TXD, 32'h99);
        chk("R7 ignored write", {24'b0, tx_byte}, 32'h42);
        @(negedge clk); tx_ack = 1;
        @(negedge clk); tx_ack = 0;
        chk("R6 tx_valid released", {31'b0, tx_valid}, 0);
        rd(A_TXC, d); chk("R6 ready restored", d, 1);
    endtask

    task automatic t_ignore;
        logic [31:0] d;
        wr(A_RXC, 32'hFF);
        rd(A_RXC, d); chk("R8 rx ctrl write ignored", d, 0);
        wr(A_TXC, 32'h0);
        rd(A_TXC, d); chk("R8 tx ctrl write ignored", d, 1);
        chk("R8 no launch", {31'b0, tx_valid}, 0);
        wr(32'hFFFF_0010, 32'hFF);
        rd(32'hFFFF_0010, d);
        chk("R8 unused reads zero", d, 0);
        chk("R8 unused acked", {31'b0, ack_s}, 1);
    endtask

    task automatic t_coincide;
        logic [31:0] d;
        push(8'h31);
        rd(A_RXD, d, 1, 8'h32); chk("R9 old byte returned", d, 32'h31);
        rd(A_RXC, d); chk("R9 ready kept, no overrun", d, 1);
        rd(A_RXD, d); chk("R9 new byte kept", d, 32'h32);
    endtask

    task automatic t_ovr_race;
        logic [31:0] d;
        push(8'h40); push(8'h41);
        rd(A_RXC, d, 1, 8'h42); chk("R10 read sees flags", d, 3);
        rd(A_RXC, d); chk("R10 overrun kept", d, 3);
        rd(A_RXC, d); chk("R10 then cleared", d, 1);
        rd(A_RXD, d); chk("R10 latest byte", d, 32'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_window();
        t_rx_basic();
        t_overrun();
        t_tx();
        t_ignore();
        t_coincide();
        t_ovr_race();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule